// File: doc/BRIEF.md
# Per-Line Interrupt State Register Bank

This block keeps the programmable state of a configurable number of shared interrupt lines and makes it available to software through a word-wide register port. For every line it stores a group bit, an enable bit, a pending bit, an active bit, an 8-bit priority and a 2-bit trigger configuration. A downstream priority selector reads the whole per-line state in parallel from dedicated output vectors. The selector and the routing logic are outside this block.

Software changes enable, pending and active through paired set and clear registers, so several agents can update single lines without a read-modify-write. Every request carries a secure qualifier. While the global security-disable flag is clear, a non-secure requester cannot see or change group assignments, and it works on priorities through a halved view that stays in the lower-urgency half of the range. The hardware interrupt inputs raise pending state. An edge-configured line latches a rising edge. A level-configured line follows its input.

Top module: `irq_dist_regs`

## Requirements
- R1: After a synchronous reset every line has priority 0xAA, group 0, enable, pending and active clear, and trigger configuration 2'b00, which means level.
- R2: A write to set-enable sets the enable bit of each line whose data bit is 1. A write to clear-enable clears those bits. Data bits that are 0 change nothing. Both registers read back the current enable bits.
- R3: Pending and active use the same set and clear semantics as enable, with one bit per line. Bit b of word k is line 32k+b.
- R4: Priority word k holds lines 4k to 4k+3. Line 4k+j sits in bits [8j+7:8j].
- R5: While the security-disable flag is 0, a non-secure priority write stores 0x80 | (value >> 1) and a non-secure priority read returns (stored << 1) & 0xFF. Secure accesses, and all accesses while the flag is 1, use the stored byte unchanged.
- R6: Configuration word k holds lines 16k to 16k+15, with line 16k+j in bits [2j+1:2j]. Bit 1 of a line's field set to 1 selects edge triggering.
- R7: The type register (region 0, word 1) reads {14'b0, 2'b11, 5'b0, HAS_SECURITY, 5'b0, ceil(NUM_LINES/32)-1}.
- R8: Control register (region 0, word 0) layout: bit 0 enables group 0, bit 1 enables group 1, bit 4 and bit 5 are routing enables, bit 6 is the security-disable flag. Bits 4 and 5 always read 1 and ignore writes. A secure access, or any access while the flag is 1, reads {DS,1,1,0,0,G1,G0} in bits 6:0 and writes G0 and G1. Only a secure access writes DS. A non-secure access while the flag is 0 reads only bit 4 and G1, and writes only G1.
- R9: While the security-disable flag is 0, a non-secure group read returns zero and a non-secure group write is ignored.
- R10: Bits that address lines at or beyond NUM_LINES read as zero and ignore writes, with no error.
- R11: Address map (word address): bits [10:8] select the region. Region 1 holds the bit registers: bits [7:5] choose group 0, set-enable 1, clear-enable 2, set-pending 3, clear-pending 4, set-active 5, clear-active 6, and bits [4:0] choose the word. Region 2 is priority and region 3 is configuration, each with the word in bits [7:0]. Any other address raises rsp_err, returns zero and changes no state.
- R12: An edge-configured line sets pending on a rising input edge. Pending stays set after the input falls, until a clear-pending write. A clear while the input is held high stays cleared.
- R13: A level-configured line reports pending while its input is high. A set-pending write makes it pending regardless of the input. A clear-pending write removes only the software-set part.
- R14: Every request gets exactly one response one cycle later (rsp_valid). A read returns its data and a write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_secure | input | 1 | Request comes from the secure side |
| req_addr | input | 11 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped address |
| irq_in | input | NUM_LINES | Hardware interrupt inputs |
| line_group | output | NUM_LINES | Per-line group |
| line_enable | output | NUM_LINES | Per-line enable |
| line_pending | output | NUM_LINES | Per-line pending |
| line_active | output | NUM_LINES | Per-line active |
| line_prio | output | 8*NUM_LINES | Per-line stored priority |
| line_cfg | output | 2*NUM_LINES | Per-line trigger configuration |
| ctl_grp0_en | output | 1 | Group 0 enable |
| ctl_grp1_en | output | 1 | Group 1 enable |
| ctl_sec_disabled | output | 1 | Security-disable flag in effect |

## Verification
The hardest case to reach is an edge-configured line that software clears while its input is still high. The pending bit must stay clear because no new rising edge has arrived, unlike a level line. The stimulus first programs the configuration word and raises the input so the line latches. It then issues a clear-pending write with the input still high and watches the pending output for several cycles. The same ordering is repeated on a level line, where the clear must leave pending set. The priority and group tests run with the security-disable flag in both states, and the flag is changed only through a secure control write.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 11;
  localparam int WIDX_W = 8;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_TYPE, SEL_GROUP,
    SEL_EN_SET, SEL_EN_CLR,
    SEL_PD_SET, SEL_PD_CLR,
    SEL_AC_SET, SEL_AC_CLR,
    SEL_PRIO, SEL_CFG, SEL_NONE
  } reg_sel_e;

  // Value kept in the priority byte for a given write.
  function automatic logic [7:0] prio_store(input logic [7:0] v, input logic half);
    return half ? (8'h80 | {1'b0, v[7:1]}) : v;
  endfunction

  // Value shown to the requester for a stored priority byte.
  function automatic logic [7:0] prio_view(input logic [7:0] s, input logic half);
    return half ? {s[6:0], 1'b0} : s;
  endfunction
endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
  import irq_dist_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [WIDX_W-1:0] widx
);
  always_comb begin
    sel  = SEL_NONE;
    widx = '0;
    case (addr[10:8])
      3'd0: begin
        if (addr[7:0] == 8'd0)      sel = SEL_CTRL;
        else if (addr[7:0] == 8'd1) sel = SEL_TYPE;
      end
      3'd1: begin
        widx = {3'b000, addr[4:0]};
        case (addr[7:5])
          3'd0: sel = SEL_GROUP;
          3'd1: sel = SEL_EN_SET;
          3'd2: sel = SEL_EN_CLR;
          3'd3: sel = SEL_PD_SET;
          3'd4: sel = SEL_PD_CLR;
          3'd5: sel = SEL_AC_SET;
          3'd6: sel = SEL_AC_CLR;
          default: sel = SEL_NONE;
        endcase
      end
      3'd2: begin
        sel  = SEL_PRIO;
        widx = addr[7:0];
      end
      3'd3: begin
        sel  = SEL_CFG;
        widx = addr[7:0];
      end
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irq_dist_line.sv
module irq_dist_line #(
  parameter logic [7:0] RST_PRIO = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_in,
  input  logic       grp_we,
  input  logic       grp_wd,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       pd_set,
  input  logic       pd_clr,
  input  logic       ac_set,
  input  logic       ac_clr,
  input  logic       pr_we,
  input  logic [7:0] pr_wd,
  input  logic       cf_we,
  input  logic [1:0] cf_wd,
  output logic       grp_o,
  output logic       en_o,
  output logic       pend_o,
  output logic       act_o,
  output logic [7:0] prio_o,
  output logic [1:0] cfg_o
);
  logic pend_q;
  logic irq_q;
  logic irq_q2;
  logic is_edge;
  logic rise;

  assign is_edge = cfg_o[1];
  assign rise    = irq_q & ~irq_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_o  <= 1'b0;
      en_o   <= 1'b0;
      act_o  <= 1'b0;
      pend_q <= 1'b0;
      prio_o <= RST_PRIO;
      cfg_o  <= 2'b00;
      irq_q  <= 1'b0;
      irq_q2 <= 1'b0;
    end else begin
      irq_q  <= irq_in;
      irq_q2 <= irq_q;
      if (grp_we) grp_o <= grp_wd;
      en_o  <= (en_o & ~en_clr) | en_set;
      act_o <= (act_o & ~ac_clr) | ac_set;
      if (is_edge) pend_q <= (pend_q & ~pd_clr) | pd_set | rise;
      else         pend_q <= (pend_q & ~pd_clr) | pd_set;
      if (pr_we) prio_o <= pr_wd;
      if (cf_we) cfg_o  <= cf_wd;
    end
  end

  // Level lines add the sampled input to the software-set part.
  assign pend_o = pend_q | (~is_edge & irq_q);
endmodule

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             secure,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             ds_o,
  output logic             g0_o,
  output logic             g1_o
);
  logic ds_q;
  logic sec_view;

  assign ds_o     = HAS_SECURITY ? ds_q : 1'b1;
  assign sec_view = secure | ds_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_q <= 1'b0;
      g0_o <= 1'b0;
      g1_o <= 1'b0;
    end else if (we) begin
      g1_o <= wdata[1];
      if (sec_view) g0_o <= wdata[0];
      if (secure)   ds_q <= wdata[6];
    end
  end

  always_comb begin
    if (sec_view) rdata = {25'b0, ds_o, 1'b1, 1'b1, 2'b00, g1_o, g0_o};
    else          rdata = {27'b0, 1'b1, 2'b00, g1_o, 1'b0};
  end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_LINES    = 40,
  parameter bit HAS_SECURITY = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_secure,
  input  logic [10:0]            req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic                   rsp_err,
  input  logic [NUM_LINES-1:0]   irq_in,
  output logic [NUM_LINES-1:0]   line_group,
  output logic [NUM_LINES-1:0]   line_enable,
  output logic [NUM_LINES-1:0]   line_pending,
  output logic [NUM_LINES-1:0]   line_active,
  output logic [8*NUM_LINES-1:0] line_prio,
  output logic [2*NUM_LINES-1:0] line_cfg,
  output logic                   ctl_grp0_en,
  output logic                   ctl_grp1_en,
  output logic                   ctl_sec_disabled
);
  localparam int NBW = (NUM_LINES + 31) / 32;
  localparam int NPW = (NUM_LINES + 3) / 4;
  localparam int NCW = (NUM_LINES + 15) / 16;
  localparam logic [31:0] TYPE_VAL =
    32'h0003_0000 | (HAS_SECURITY ? 32'h0000_0400 : 32'h0) | 32'(NBW - 1);

  reg_sel_e          sel;
  logic [WIDX_W-1:0] widx;
  logic              wr;
  logic              ns_half;
  logic [31:0]       ctrl_rd;
  logic [31:0]       rd;
  logic [31:0]       pw;

  logic [NBW*32-1:0] grp_pad, en_pad, pd_pad, ac_pad;
  logic [NPW*32-1:0] prio_pad;
  logic [NCW*32-1:0] cfg_pad;

  irq_dist_decode u_dec (
    .addr (req_addr),
    .sel  (sel),
    .widx (widx)
  );

  assign wr      = req_valid & req_write;
  assign ns_half = ~ctl_sec_disabled & ~req_secure;

  irq_dist_ctrl #(.HAS_SECURITY(HAS_SECURITY)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (wr && sel == SEL_CTRL),
    .secure (req_secure),
    .wdata  (req_wdata),
    .rdata  (ctrl_rd),
    .ds_o   (ctl_sec_disabled),
    .g0_o   (ctl_grp0_en),
    .g1_o   (ctl_grp1_en)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int BW = i / 32;
    localparam int BB = i % 32;
    localparam int PW = i / 4;
    localparam int PB = i % 4;
    localparam int CW = i / 16;
    localparam int CB = i % 16;

    logic bit_hit;
    logic pr_hit;
    logic cf_hit;

    assign bit_hit = wr && (widx == WIDX_W'(BW)) && req_wdata[BB];
    assign pr_hit  = wr && sel == SEL_PRIO && (widx == WIDX_W'(PW));
    assign cf_hit  = wr && sel == SEL_CFG && (widx == WIDX_W'(CW));

    irq_dist_line u_line (
      .clk    (clk),
      .rst    (rst),
      .irq_in (irq_in[i]),
      .grp_we (wr && sel == SEL_GROUP && (widx == WIDX_W'(BW)) && !ns_half),
      .grp_wd (req_wdata[BB]),
      .en_set (bit_hit && sel == SEL_EN_SET),
      .en_clr (bit_hit && sel == SEL_EN_CLR),
      .pd_set (bit_hit && sel == SEL_PD_SET),
      .pd_clr (bit_hit && sel == SEL_PD_CLR),
      .ac_set (bit_hit && sel == SEL_AC_SET),
      .ac_clr (bit_hit && sel == SEL_AC_CLR),
      .pr_we  (pr_hit),
      .pr_wd  (prio_store(req_wdata[8*PB +: 8], ns_half)),
      .cf_we  (cf_hit),
      .cf_wd  (req_wdata[2*CB +: 2]),
      .grp_o  (line_group[i]),
      .en_o   (line_enable[i]),
      .pend_o (line_pending[i]),
      .act_o  (line_active[i]),
      .prio_o (line_prio[8*i +: 8]),
      .cfg_o  (line_cfg[2*i +: 2])
    );
  end

  // Zero-extended copies so that a whole register word can be sliced out.
  assign grp_pad  = (NBW*32)'(line_group);
  assign en_pad   = (NBW*32)'(line_enable);
  assign pd_pad   = (NBW*32)'(line_pending);
  assign ac_pad   = (NBW*32)'(line_active);
  assign prio_pad = (NPW*32)'(line_prio);
  assign cfg_pad  = (NCW*32)'(line_cfg);

  always_comb begin
    int wi;
    wi = int'(widx);
    rd = '0;
    pw = '0;
    case (sel)
      SEL_CTRL: rd = ctrl_rd;
      SEL_TYPE: rd = TYPE_VAL;
      SEL_GROUP: if (!ns_half && wi < NBW) rd = grp_pad[wi*32 +: 32];
      SEL_EN_SET, SEL_EN_CLR: if (wi < NBW) rd = en_pad[wi*32 +: 32];
      SEL_PD_SET, SEL_PD_CLR: if (wi < NBW) rd = pd_pad[wi*32 +: 32];
      SEL_AC_SET, SEL_AC_CLR: if (wi < NBW) rd = ac_pad[wi*32 +: 32];
      SEL_PRIO: begin
        if (wi < NPW) pw = prio_pad[wi*32 +: 32];
        for (int b = 0; b < 4; b++) rd[8*b +: 8] = prio_view(pw[8*b +: 8], ns_half);
      end
      SEL_CFG: if (wi < NCW) rd = cfg_pad[wi*32 +: 32];
      default: rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && sel == SEL_NONE;
      rsp_rdata <= (req_valid && !req_write) ? rd : '0;
    end
  end
endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int N = 40
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_write,
  input logic           req_secure,
  input logic [10:0]    req_addr,
  input logic           rsp_valid,
  input logic [31:0]    rsp_rdata,
  input logic           rsp_err,
  input logic [N-1:0]   line_group,
  input logic [N-1:0]   line_enable,
  input logic [N-1:0]   line_pending,
  input logic [8*N-1:0] line_prio,
  input logic [2*N-1:0] line_cfg,
  input logic           ctl_sec_disabled
);
  a_r14_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r14_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r11_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == 32'h0));
  a_r2_enable_held: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(line_enable));
  a_r4_prio_held: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(line_prio));
  a_r6_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(line_cfg));
  a_r9_group_guarded: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_secure && !ctl_sec_disabled) |=> $stable(line_group));
  a_r8_routing_ones: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_secure && req_addr == 11'd0) |=> (rsp_rdata[5:4] == 2'b11));

  for (genvar i = 0; i < N; i++) begin : g_edge
    a_r12_edge_latched: assert property (@(posedge clk) disable iff (rst)
      (line_cfg[2*i+1] && line_pending[i] && !(req_valid && req_write)) |=> line_pending[i]);
  end
endmodule

bind irq_dist_regs irq_dist_regs_chk #(.N(NUM_LINES)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_write        (req_write),
  .req_secure       (req_secure),
  .req_addr         (req_addr),
  .rsp_valid        (rsp_valid),
  .rsp_rdata        (rsp_rdata),
  .rsp_err          (rsp_err),
  .line_group       (line_group),
  .line_enable      (line_enable),
  .line_pending     (line_pending),
  .line_prio        (line_prio),
  .line_cfg         (line_cfg),
  .ctl_sec_disabled (ctl_sec_disabled)
);

// File: tb/irq_dist_regs_bench.sv
`timescale 1ns/1ps
module irq_dist_regs_bench;
  localparam int N = 40;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic           req_secure = 1'b0;
  logic [10:0]    req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           rsp_valid;
  logic [31:0]    rsp_rdata;
  logic           rsp_err;
  logic [N-1:0]   irq_in = '0;
  logic [N-1:0]   line_group, line_enable, line_pending, line_active;
  logic [8*N-1:0] line_prio;
  logic [2*N-1:0] line_cfg;
  logic           ctl_grp0_en, ctl_grp1_en, ctl_sec_disabled;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  irq_dist_regs #(.NUM_LINES(N), .HAS_SECURITY(1'b1)) u_irq_dist_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_in(irq_in),
    .line_group(line_group), .line_enable(line_enable),
    .line_pending(line_pending), .line_active(line_active),
    .line_prio(line_prio), .line_cfg(line_cfg),
    .ctl_grp0_en(ctl_grp0_en), .ctl_grp1_en(ctl_grp1_en),
    .ctl_sec_disabled(ctl_sec_disabled)
  );

  function automatic logic [10:0] a_bit(input int sub, input int w);
    return {3'd1, 3'(sub), 5'(w)};
  endfunction
  function automatic logic [10:0] a_pr(input int k);
    return {3'd2, 8'(k)};
  endfunction
  function automatic logic [10:0] a_cf(input int k);
    return {3'd3, 8'(k)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issues one request and queues the response it must produce.
  task automatic op(input bit wr, input bit sec, input logic [10:0] a,
                    input logic [31:0] d, input logic [31:0] exp_d,
                    input bit exp_e, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_secure = sec;
    req_addr   = a;
    req_wdata  = d;
    e.data = exp_d; e.err = exp_e; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input bit sec, input logic [10:0] a, input logic [31:0] exp_d, input string tag);
    op(1'b0, sec, a, 32'h0, exp_d, 1'b0, tag);
  endtask
  task automatic wr(input bit sec, input logic [10:0] a, input logic [31:0] d, input string tag);
    op(1'b1, sec, a, d, 32'h0, 1'b0, tag);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: pops the expected response whenever the design answers.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R14 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " data"}, 64'(rsp_rdata), 64'(e.data));
        chk({e.tag, " err"}, 64'(rsp_err), 64'(e.err));
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8*N-1:0] prio_exp;
    for (int i = 0; i < N; i++) prio_exp[8*i +: 8] = 8'hAA;
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 prio", 64'(line_prio == prio_exp), 64'd1);
    chk("R1 group/en/pend/act", 64'(line_group | line_enable | line_pending | line_active), 64'd0);
    chk("R1 cfg", 64'(line_cfg), 64'd0);
    rd(1, a_pr(0), 32'hAAAA_AAAA, "R1 prio read");
    rd(1, a_cf(0), 32'h0, "R1 cfg read");
    rd(1, a_bit(1, 0), 32'h0, "R1 enable read");

    // R7 type, R8 control after reset
    rd(1, 11'd1, 32'h0003_0401, "R7 type");
    rd(1, 11'd0, 32'h0000_0030, "R8 ctrl secure reset");

    // R2 enable set/clear
    wr(1, a_bit(1, 0), 32'h5, "R2 set en");
    rd(1, a_bit(1, 0), 32'h5, "R2 set-en read");
    wr(1, a_bit(1, 0), 32'h0, "R2 set zero");
    rd(1, a_bit(2, 0), 32'h5, "R2 clr-en read");
    wr(1, a_bit(2, 0), 32'h1, "R2 clr en");
    rd(1, a_bit(1, 0), 32'h4, "R2 after clear");
    // R10 partial word
    wr(1, a_bit(1, 1), 32'hFFFF_FFFF, "R10 set en word1");
    rd(1, a_bit(1, 1), 32'h0000_00FF, "R10 en word1 read");
    chk("R2 R10 enable vector", 64'(line_enable), 64'h00FF_0000_0004);

    // R3 active and pending
    wr(1, a_bit(5, 0), 32'h8000_0000, "R3 set act");
    rd(1, a_bit(6, 0), 32'h8000_0000, "R3 act read");
    chk("R3 active line31", 64'(line_active[31]), 64'd1);
    wr(1, a_bit(6, 0), 32'h8000_0000, "R3 clr act");
    rd(1, a_bit(5, 0), 32'h0, "R3 act cleared");
    wr(1, a_bit(3, 0), 32'h8, "R3 set pend");
    rd(1, a_bit(3, 0), 32'h8, "R3 pend read");
    wr(1, a_bit(4, 0), 32'h8, "R3 clr pend");
    rd(1, a_bit(4, 0), 32'h0, "R3 pend cleared");

    // R4 packing
    wr(1, a_pr(1), 32'h1122_3344, "R4 prio write");
    chk("R4 line4", 64'(line_prio[8*4 +: 8]), 64'h44);
    chk("R4 line7", 64'(line_prio[8*7 +: 8]), 64'h11);
    rd(1, a_pr(1), 32'h1122_3344, "R4 prio read");

    // R5 half view while security-disable is 0
    wr(0, a_pr(2), 32'h00FF_7F02, "R5 ns prio write");
    chk("R5 stored word2", 64'(line_prio[8*8 +: 32]), 64'h80FF_BF81);
    rd(0, a_pr(2), 32'h00FE_7E02, "R5 ns prio read");
    rd(1, a_pr(2), 32'h80FF_BF81, "R5 secure prio read");
    rd(0, a_pr(0), 32'h5454_5454, "R5 ns view of reset");

    // R9 group protection
    wr(0, a_bit(0, 0), 32'hFFFF_FFFF, "R9 ns group write");
    chk("R9 group unchanged", 64'(line_group), 64'd0);
    wr(1, a_bit(0, 0), 32'hF, "R9 secure group write");
    rd(1, a_bit(0, 0), 32'hF, "R9 secure group read");
    rd(0, a_bit(0, 0), 32'h0, "R9 ns group read zero");

    // R8 control views
    wr(0, 11'd0, 32'h43, "R8 ns ctrl write");
    rd(1, 11'd0, 32'h32, "R8 secure after ns write");
    rd(0, 11'd0, 32'h12, "R8 ns view");
    wr(1, 11'd0, 32'h0, "R8 secure write zero");
    rd(1, 11'd0, 32'h30, "R8 routing bits stay");
    wr(1, 11'd0, 32'h41, "R8 set ds");
    rd(1, 11'd0, 32'h71, "R8 secure ds view");
    rd(0, 11'd0, 32'h71, "R8 ns ds view");
    chk("R8 ctl outputs", 64'({ctl_sec_disabled, ctl_grp1_en, ctl_grp0_en}), 64'b101);

    // R5 / R9 with security disabled
    wr(0, a_pr(3), 32'h10, "R5 ds ns prio write");
    rd(0, a_pr(3), 32'h10, "R5 ds full view");
    wr(0, a_bit(0, 1), 32'h1, "R9 ds ns group write");
    rd(0, a_bit(0, 1), 32'h1, "R9 ds ns group read");

    // R6 configuration
    wr(1, a_cf(0), 32'h8, "R6 cfg line1 edge");
    rd(1, a_cf(0), 32'h8, "R6 cfg read");
    chk("R6 line1 field", 64'(line_cfg[3:2]), 64'd2);
    wr(1, a_cf(2), 32'hFFFF_FFFF, "R10 cfg word2");
    rd(1, a_cf(2), 32'h0000_FFFF, "R10 cfg word2 read");

    // R12 edge line 1
    @(negedge clk); irq_in[1] = 1'b1;
    idle(3);
    chk("R12 edge latched", 64'(line_pending[1]), 64'd1);
    irq_in[1] = 1'b0;
    idle(3);
    chk("R12 held after fall", 64'(line_pending[1]), 64'd1);
    rd(1, a_bit(3, 0), 32'h2, "R12 pend read");
    wr(1, a_bit(4, 0), 32'h2, "R12 clear");
    chk("R12 cleared", 64'(line_pending[1]), 64'd0);
    irq_in[1] = 1'b1;
    idle(3);
    chk("R12 second edge", 64'(line_pending[1]), 64'd1);
    wr(1, a_bit(4, 0), 32'h2, "R12 clear while high");
    idle(3);
    chk("R12 no relatch while high", 64'(line_pending[1]), 64'd0);
    irq_in[1] = 1'b0;

    // R13 level line 5
    @(negedge clk); irq_in[5] = 1'b1;
    idle(2);
    chk("R13 level high", 64'(line_pending[5]), 64'd1);
    irq_in[5] = 1'b0;
    idle(2);
    chk("R13 level low", 64'(line_pending[5]), 64'd0);
    wr(1, a_bit(3, 0), 32'h20, "R13 sw set");
    idle(2);
    chk("R13 sw pend holds", 64'(line_pending[5]), 64'd1);
    rd(1, a_bit(3, 0), 32'h20, "R13 pend read");
    wr(1, a_bit(4, 0), 32'h20, "R13 sw clear");
    chk("R13 sw cleared", 64'(line_pending[5]), 64'd0);
    irq_in[5] = 1'b1;
    idle(2);
    wr(1, a_bit(4, 0), 32'h20, "R13 clear while level high");
    chk("R13 level survives clear", 64'(line_pending[5]), 64'd1);
    irq_in[5] = 1'b0;

    // R10 beyond line count, R11 unmapped
    rd(1, a_bit(0, 5), 32'h0, "R10 group word5");
    wr(1, a_bit(1, 3), 32'hFFFF_FFFF, "R10 set en word3");
    chk("R10 enable unchanged", 64'(line_enable), 64'h00FF_0000_0004);
    op(0, 1, 11'h002, 32'h0, 32'h0, 1'b1, "R11 read unmapped ctl");
    op(0, 1, a_bit(7, 0), 32'h0, 32'h0, 1'b1, "R11 read sub7");
    op(1, 1, 11'h400, 32'hFFFF_FFFF, 32'h0, 1'b1, "R11 write unmapped");
    chk("R11 no state change", 64'(line_enable), 64'h00FF_0000_0004);

    idle(3);
    chk("R14 all responses seen", 64'(expq.size()), 64'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule